// File: doc/BRIEF.md
# Sync-Locked Burst Scheduler

This block decides the moment at which each charge-transfer acquisition burst begins. After reset it waits out a start-up hold-off. After that it runs in one of two ways. In free-running mode it launches a new burst a fixed discharge gap after the measurement engine reports the end of the previous one. In locked mode it waits for a rising edge on an external sync pin, for example one derived from the mains, so that periodic interference stays correlated with the samples.

The sync pin is brought into the system clock domain through a two-flop synchronizer and edge-detected there. Every rising edge seen after the hold-off refreshes a loss-of-sync timer and raises the locked status. If no edge arrives within the loss window, the status falls and free-running timing resumes. An edge that lands while a burst is in progress, or during the discharge gap that follows it, is dropped rather than remembered. All timers count a one-microsecond tick made by dividing the system clock by `CLK_PER_US`.

Top module: `burst_sched`

## Requirements
- R1: For `POWERUP_US` microseconds after reset, `burst_start` and `sync_locked` stay low. Sync edges seen in that interval have no effect, either then or later.
- R2: When the hold-off expires with no lock, the first `burst_start` comes one clock after the hold-off interval ends.
- R3: In free-running mode, the next `burst_start` comes `GAP_US` microseconds plus one clock after the clock edge at which `burst_done` is sampled high.
- R4: `burst_start` is a single-clock pulse. No further pulse is issued until `burst_done` has been seen and the gap has elapsed.
- R5: While locked and waiting, a rising edge on `sync_in` produces `burst_start` on the third rising clock edge after the pin rises (two synchronizer stages plus the output register).
- R6: Sync edges that arrive during a burst or during the gap after it do not start a burst and are not queued. The first rising edge after the gap starts the next burst.
- R7: Any rising sync edge after the hold-off sets `sync_locked` and restarts the loss timer, even when the edge falls in a blocked window. A train of edges that begins during free-running stops the free-run start that would otherwise follow the gap.
- R8: When `LOSS_US` microseconds pass without a rising sync edge, `sync_locked` falls. A scheduler that is waiting then issues `burst_start` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; releasing it marks power-up |
| sync_in | input | 1 | Asynchronous external sync pin; rising edges request bursts |
| burst_done | input | 1 | One-clock flag from the measurement engine: the current burst has ended |
| burst_start | output | 1 | One-clock pulse that launches a burst |
| sync_locked | output | 1 | High while a sync edge has been seen within the loss window |

## Verification
A locked start is due three clock edges after the sync pin rises. A free-running start is due one edge after the gap or hold-off count expires, and the gap count begins at the edge that samples `burst_done`. The loss of lock lands exactly `LOSS_US` ticks after the last accepted edge, and the waiting start follows one edge later. The bench works out each start cycle from these rules ahead of time and queues it. The monitor samples on the falling clock edge and matches each observed pulse against the head of the queue with a one-cycle margin. The lock status is compared at fixed cycles placed well clear of any transition.

// File: rtl/burst_sched.sv
module burst_sched #(
  parameter int CLK_PER_US = 50,
  parameter int POWERUP_US = 300000,
  parameter int GAP_US     = 2500,
  parameter int LOSS_US    = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic burst_done,
  output logic burst_start,
  output logic sync_locked
);
  localparam int DW    = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int MAXUS = (POWERUP_US > LOSS_US) ?
                         ((POWERUP_US > GAP_US) ? POWERUP_US : GAP_US) :
                         ((LOSS_US > GAP_US) ? LOSS_US : GAP_US);
  localparam int UW    = $clog2(MAXUS + 1);

  typedef enum logic [1:0] {S_HOLD, S_READY, S_BURST, S_GAP} st_t;

  st_t state, nxt;
  logic [2:0]    sy;
  logic [DW-1:0] pdiv, ldiv;
  logic [UW-1:0] pus, lus;

  wire rise  = sy[1] & ~sy[2];
  wire ptick = (pdiv == DW'(CLK_PER_US - 1));
  wire ltick = (ldiv == DW'(CLK_PER_US - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy <= '0;
    else        sy <= {sy[1:0], sync_in};

  always_comb begin
    nxt = state;
    case (state)
      S_HOLD:  if (ptick && pus == UW'(POWERUP_US - 1)) nxt = S_READY;
      S_READY: if (!sync_locked || rise) nxt = S_BURST;
      S_BURST: if (burst_done) nxt = S_GAP;
      S_GAP:   if (ptick && pus == UW'(GAP_US - 1)) nxt = S_READY;
      default: nxt = S_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_HOLD;
      burst_start <= 1'b0;
      pdiv        <= '0;
      pus         <= '0;
    end else begin
      state       <= nxt;
      burst_start <= (state == S_READY) && (nxt == S_BURST);
      if (nxt != state) begin
        pdiv <= '0;
        pus  <= '0;
      end else begin
        pdiv <= ptick ? '0 : pdiv + 1'b1;
        if (ptick) pus <= pus + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_locked <= 1'b0;
      ldiv        <= '0;
      lus         <= '0;
    end else if (rise && state != S_HOLD) begin
      sync_locked <= 1'b1;
      ldiv        <= '0;
      lus         <= '0;
    end else if (sync_locked) begin
      ldiv <= ltick ? '0 : ldiv + 1'b1;
      if (ltick) begin
        lus <= lus + 1'b1;
        if (lus == UW'(LOSS_US - 1)) sync_locked <= 1'b0;
      end
    end
  end

  assert_quiet_holdoff_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD) |-> (!sync_locked && !burst_start));

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> !burst_start);

  assert_start_enters_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> (state == S_BURST));

  assert_free_run_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_READY && !sync_locked) |=> burst_start);

  assert_blocked_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && (state == S_BURST || state == S_GAP)) |=> !burst_start);

  assert_edge_locks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && state != S_HOLD) |=> sync_locked);

  assert_locked_edge_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && state == S_READY) |=> burst_start);
endmodule

// File: tb/burst_sched_bench.sv
module burst_sched_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b0;
  logic burst_done = 1'b0;
  logic burst_start, sync_locked;
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done_flag = 0;

  typedef struct { int c; string r; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  burst_sched #(.CLK_PER_US(2), .POWERUP_US(20), .GAP_US(5), .LOSS_US(40)) u_burst_sched (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .burst_done(burst_done),
    .burst_start(burst_start), .sync_locked(sync_locked));

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic expect_start(input int c, input string r);
    exp_t e;
    e.c = c; e.r = r;
    q.push_back(e);
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic pulse(input int t);
    wait_cyc(t);
    sync_in = 1'b1;
    wait_cyc(t + 2);
    sync_in = 1'b0;
  endtask

  task automatic chk_lock(input logic exp, input string r);
    checks++;
    if (sync_locked !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d sync_locked=%b expected %b", r, cyc, sync_locked, exp);
    end
  endtask

  int  dcnt = 0;
  bit  prev_start = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_start) begin
        checks++;
        if (burst_start) begin
          fails++;
          $display("FAIL R4 cycle %0d burst_start=1 expected 0 after pulse", cyc);
        end
      end
      if (burst_start) begin
        exp_t e;
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R6 cycle %0d unexpected burst_start, expected none", cyc);
        end else begin
          e = q.pop_front();
          if (cyc < e.c - 1 || cyc > e.c + 1) begin
            fails++;
            $display("FAIL %s burst_start at cycle %0d expected %0d", e.r, cyc, e.c);
          end
        end
        dcnt = 6;
        burst_done = 1'b0;
      end else if (dcnt > 0) begin
        dcnt--;
        burst_done = (dcnt == 0);
      end else begin
        burst_done = 1'b0;
      end
      prev_start = burst_start;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (burst_start !== 1'b0 || sync_locked !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset start=%b locked=%b expected 0 0", burst_start, sync_locked);
    end
    expect_start(41, "R2");
    expect_start(59, "R3");
    expect_start(77, "R3");
    expect_start(95, "R3");
    expect_start(113, "R3");
    expect_start(148, "R5");
    expect_start(178, "R5");
    expect_start(208, "R5");
    expect_start(230, "R6");
    expect_start(311, "R8");
    expect_start(329, "R3");
    expect_start(347, "R3");
    rst_n = 1'b1;
    pulse(10);
    pulse(20);
    wait_cyc(30);  chk_lock(1'b0, "R1");
    wait_cyc(100); chk_lock(1'b0, "R3");
    pulse(115);
    wait_cyc(119); chk_lock(1'b1, "R7");
    pulse(145);
    pulse(175);
    pulse(205);
    pulse(213);
    pulse(219);
    pulse(227);
    wait_cyc(300); chk_lock(1'b1, "R8");
    wait_cyc(312); chk_lock(1'b0, "R8");
    wait_cyc(360);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL %s missing burst_start, %0d outstanding expected 0 (next due %0d)",
               q[0].r, q.size(), q[0].c);
    end
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      fails++;
      $display("FAIL watchdog cycle %0d expected finish by 360", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule